// File: doc/BRIEF.md
# Instruction Fetch Way-Enable Controller

This block decides which ways of a set-associative instruction cache are switched on for the next fetch. When a fetch completes and the branch target buffer lookup carries a way prediction, only that single way is enabled, which saves array energy. When no prediction is available, every way is enabled so that the fetch cannot miss for lack of a prediction.

When a branch resolves as mispredicted, the fetch unit is redirected. The branch carries the way predictions saved in its buffer entry: one for the line holding its target and one for the line holding its fall-through address. If the branch had a buffer entry and the corrected address matches one of those two addresses, the matching saved way is enabled. Every other redirect enables all ways. The mask is registered and changes on the clock edge that follows the qualifying input.

Top module: `wen_ctrl`

## Requirements
- R1: When fetch_done_i is high, redir_i is low and lkp_hit_i is high, the next mask is one-hot with bit k set, where k is lkp_way_i (bit k stands for way k).
- R2: When fetch_done_i is high, redir_i is low and lkp_hit_i is low, the next mask is all ones.
- R3: When redir_i and br_hit_i are high and redir_addr_i equals br_tgt_i, the next mask is one-hot at index br_twp_i.
- R4: When redir_i and br_hit_i are high and redir_addr_i equals br_fall_i but not br_tgt_i, the next mask is one-hot at index br_fwp_i.
- R5: When redir_i is high and either br_hit_i is low or redir_addr_i matches neither br_tgt_i nor br_fall_i, the next mask is all ones.
- R6: When redir_i and fetch_done_i are high in the same cycle, the redirect decides the mask and the lookup inputs are ignored.
- R7: While rst_ni is low, and after reset until the first fetch completion or redirect, the mask is all ones.
- R8: The mask is always either one-hot or all ones. It is never all zeros.
- R9: In a cycle with both fetch_done_i and redir_i low, the mask keeps its value.
- R10: When redir_addr_i equals both br_tgt_i and br_fall_i on a redirect with br_hit_i high, br_twp_i is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_done_i | input | 1 | The current fetch has finished |
| lkp_hit_i | input | 1 | The buffer lookup returned a way prediction |
| lkp_way_i | input | WAY_W | Predicted way from the lookup |
| redir_i | input | 1 | Branch mispredict redirect |
| redir_addr_i | input | ADDR_W | Corrected fetch address |
| br_hit_i | input | 1 | The resolving branch had a buffer entry |
| br_tgt_i | input | ADDR_W | The branch's predicted target address |
| br_fall_i | input | ADDR_W | The branch's fall-through address |
| br_twp_i | input | WAY_W | Saved way for the target line |
| br_fwp_i | input | WAY_W | Saved way for the fall-through line |
| way_en_o | output | NUM_WAYS | Way-enable mask for the next fetch |

## Verification
Every result is due exactly one rising edge after the stimulus: inputs are applied on a falling edge, the register captures them on the next rising edge, and the mask is compared 1 ns later. The driver pushes the mask expected from the requirements for each stimulus cycle, and the monitor pops one entry per rising edge, so each comparison falls in the cycle where the value appears. Hold cycles push the previous expected mask, which checks that the value is retained. Reset is checked directly while rst_ni is low.

// File: rtl/wen_pkg.sv
package wen_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ALL  = 2'd1,
    SRC_ONE  = 2'd2
  } wen_src_e;
endpackage

// File: rtl/wen_onehot.sv
module wen_onehot #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [WAY_W-1:0]    idx_i,
  output logic [NUM_WAYS-1:0] oh_o
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_bit
    assign oh_o[g] = (idx_i == WAY_W'(g));
  end
endmodule

// File: rtl/wen_redir_sel.sv
module wen_redir_sel
  import wen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 2
) (
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  input  logic              br_hit_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic [ADDR_W-1:0] br_fall_i,
  input  logic [WAY_W-1:0]  br_twp_i,
  input  logic [WAY_W-1:0]  br_fwp_i,
  output wen_src_e          src_o,
  output logic [WAY_W-1:0]  way_o
);
  logic tgt_match, fall_match;
  assign tgt_match  = br_hit_i && (redir_addr_i == br_tgt_i);
  assign fall_match = br_hit_i && (redir_addr_i == br_fall_i);

  always_comb begin
    src_o = SRC_HOLD;
    way_o = '0;
    if (redir_i) begin
      // target line checked first
      if (tgt_match) begin
        src_o = SRC_ONE;
        way_o = br_twp_i;
      end else if (fall_match) begin
        src_o = SRC_ONE;
        way_o = br_fwp_i;
      end else begin
        src_o = SRC_ALL;
      end
    end
  end
endmodule

// File: rtl/wen_fetch_sel.sv
module wen_fetch_sel
  import wen_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             fetch_done_i,
  input  logic             lkp_hit_i,
  input  logic [WAY_W-1:0] lkp_way_i,
  output wen_src_e         src_o,
  output logic [WAY_W-1:0] way_o
);
  always_comb begin
    src_o = SRC_HOLD;
    way_o = lkp_way_i;
    if (fetch_done_i) src_o = lkp_hit_i ? SRC_ONE : SRC_ALL;
  end
endmodule

// File: rtl/wen_ctrl.sv
module wen_ctrl
  import wen_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int ADDR_W   = 32,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_done_i,
  input  logic                lkp_hit_i,
  input  logic [WAY_W-1:0]    lkp_way_i,
  input  logic                redir_i,
  input  logic [ADDR_W-1:0]   redir_addr_i,
  input  logic                br_hit_i,
  input  logic [ADDR_W-1:0]   br_tgt_i,
  input  logic [ADDR_W-1:0]   br_fall_i,
  input  logic [WAY_W-1:0]    br_twp_i,
  input  logic [WAY_W-1:0]    br_fwp_i,
  output logic [NUM_WAYS-1:0] way_en_o
);
  wen_src_e          rd_src, fd_src, sel_src;
  logic [WAY_W-1:0]  rd_way, fd_way, sel_way;
  logic [NUM_WAYS-1:0] sel_oh, mask_d, mask_q;

  wen_redir_sel #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_redir (
    .redir_i      (redir_i),
    .redir_addr_i (redir_addr_i),
    .br_hit_i     (br_hit_i),
    .br_tgt_i     (br_tgt_i),
    .br_fall_i    (br_fall_i),
    .br_twp_i     (br_twp_i),
    .br_fwp_i     (br_fwp_i),
    .src_o        (rd_src),
    .way_o        (rd_way)
  );

  wen_fetch_sel #(.WAY_W(WAY_W)) u_fetch (
    .fetch_done_i (fetch_done_i),
    .lkp_hit_i    (lkp_hit_i),
    .lkp_way_i    (lkp_way_i),
    .src_o        (fd_src),
    .way_o        (fd_way)
  );

  // redirect wins over normal fetch completion
  assign sel_src = (rd_src != SRC_HOLD) ? rd_src : fd_src;
  assign sel_way = (rd_src != SRC_HOLD) ? rd_way : fd_way;

  wen_onehot #(.NUM_WAYS(NUM_WAYS)) u_oh (
    .idx_i (sel_way),
    .oh_o  (sel_oh)
  );

  always_comb begin
    unique case (sel_src)
      SRC_ONE: mask_d = sel_oh;
      SRC_ALL: mask_d = '1;
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign way_en_o = mask_q;

  p_legal_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(way_en_o) || (&way_en_o));

  p_pred_way_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && !redir_i && lkp_hit_i)
      |=> ($onehot(way_en_o) && way_en_o[$past(lkp_way_i)]));

  p_no_pred_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && !redir_i && !lkp_hit_i) |=> (&way_en_o));

  p_redir_tgt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && br_hit_i && redir_addr_i == br_tgt_i)
      |=> ($onehot(way_en_o) && way_en_o[$past(br_twp_i)]));

  p_redir_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && br_hit_i && redir_addr_i != br_tgt_i && redir_addr_i == br_fall_i)
      |=> ($onehot(way_en_o) && way_en_o[$past(br_fwp_i)]));

  p_redir_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && (!br_hit_i || (redir_addr_i != br_tgt_i && redir_addr_i != br_fall_i)))
      |=> (&way_en_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_done_i && !redir_i) |=> $stable(way_en_o));
endmodule

// File: tb/sim_wen_ctrl.sv
`timescale 1ns/1ps
module sim_wen_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_done, lkp_hit, redir, br_hit;
  logic [1:0]  lkp_way, twp, fwp;
  logic [31:0] raddr, tgt, fall;
  logic [3:0]  way_en;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] model = 4'hF;
  bit         done = 0;

  always #2 clk = ~clk;

  wen_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_done_i(fetch_done), .lkp_hit_i(lkp_hit),
    .lkp_way_i(lkp_way), .redir_i(redir), .redir_addr_i(raddr), .br_hit_i(br_hit),
    .br_tgt_i(tgt), .br_fall_i(fall), .br_twp_i(twp), .br_fwp_i(fwp), .way_en_o(way_en)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected mask
  task automatic step(input logic fd, input logic hit, input logic [1:0] lw,
                      input logic rd, input logic bh, input logic [31:0] ra,
                      input logic [31:0] t, input logic [31:0] f,
                      input logic [1:0] tw, input logic [1:0] fw, input string tag);
    @(negedge clk);
    fetch_done = fd; lkp_hit = hit; lkp_way = lw; redir = rd; br_hit = bh;
    raddr = ra; tgt = t; fall = f; twp = tw; fwp = fw;
    if (rd) begin
      if (bh && ra == t)      model = 4'b0001 << tw;
      else if (bh && ra == f) model = 4'b0001 << fw;
      else                    model = 4'hF;
    end else if (fd) begin
      model = hit ? (4'b0001 << lw) : 4'hF;
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: one result per rising edge, sampled 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(way_en, e, t);
        check(4'(($countones(way_en) == 1 || way_en == 4'hF)), 4'h1, "R8 legal mask");
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fetch_done = 0; lkp_hit = 0; lkp_way = 0; redir = 0; br_hit = 0;
    raddr = 0; tgt = 0; fall = 0; twp = 0; fwp = 0;
    repeat (3) @(negedge clk);
    check(way_en, 4'hF, "R7 during reset");
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle after reset");
    step(0, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R7 lookup without fetch_done");
    for (int w = 0; w < 4; w++)
      step(1, 1, 2'(w), 0, 0, 0, 0, 0, 0, 0, "R1 predicted way");
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R9 hold one-hot");
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 no prediction");
    step(0, 0, 0, 0, 1, 32'h40, 32'h40, 32'h80, 1, 2, "R9 hold all-ones");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 back to one way");
    step(0, 0, 0, 1, 1, 32'h1000, 32'h1000, 32'h2000, 3, 1, "R3 target way");
    step(0, 0, 0, 1, 1, 32'h2000, 32'h1000, 32'h2000, 3, 1, "R4 fall-through way");
    step(0, 0, 0, 1, 1, 32'h3000, 32'h1000, 32'h2000, 3, 1, "R5 no match");
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R1 way 2");
    step(0, 0, 0, 1, 0, 32'h1000, 32'h1000, 32'h2000, 3, 1, "R5 branch missed buffer");
    step(1, 1, 0, 1, 1, 32'h1000, 32'h1000, 32'h2000, 2, 1, "R6 redirect wins target");
    step(1, 1, 3, 1, 1, 32'h2000, 32'h1000, 32'h2000, 2, 0, "R6 redirect wins fall");
    step(1, 1, 1, 1, 1, 32'h5000, 32'h1000, 32'h2000, 2, 0, "R6 redirect wins all");
    step(0, 0, 0, 1, 1, 32'h7000, 32'h7000, 32'h7000, 1, 3, "R10 target before fall");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 hold after redirect");
    @(negedge clk); fetch_done = 0; redir = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule